// File: doc/BRIEF.md
# Burst-of-Two Separate-I/O SRAM Core

This block is a synchronous static memory with one port for reads and a separate port for writes. Both ports can take a command in the same cycle. Every access moves exactly two narrow beats on its bus. Each double-data-rate half-cycle is modelled as one cycle of a single system clock, so a beat lasts one clock cycle.

The storage word is twice as wide as either data bus. The array is therefore addressed with one bit fewer than the beat-level depth would need.

On the write side, the first beat arrives in the same cycle as the command and the second beat in the next cycle. Each beat brings its own active-low nibble enables. The two beats are joined and written into one array word in a single operation.

On the read side, one array word is fetched and returned as two beats, low half first. A strobe marks every cycle that carries read data.

The read and write paths are coherent. A read issued in the same cycle as a write, or later, sees the written data, including when the array is still merging that write.

Top module: `sio_b2_sram`

## Requirements
- R1: A read command and a write command presented in the same cycle are both accepted and both carried out.
- R2: A read accepted in cycle t drives the low half of the addressed word (bits DATA_W-1:0) on `rd_data` in cycle t+2 and the high half in cycle t+3, with `rd_echo` high in both cycles.
- R3: In every cycle without a read beat, `rd_echo` is low and `rd_data` is all zeros.
- R4: A write accepted in cycle t stores the `wr_data` of cycle t as the low half and the `wr_data` of cycle t+1 as the high half of the word at `wr_addr`.
- R5: `wr_nmask` is active low. Bit i, when 0, writes data bits 4i+3:4i of its beat. When 1, the same nibble of the stored word keeps its previous value.
- R6: The enables are taken separately with each beat: those of cycle t qualify the low half, and those of cycle t+1 qualify the high half.
- R7: On each port, a command in the cycle right after an accepted command is ignored. That cycle belongs to the second beat of the running burst.
- R8: Reads accepted every second cycle produce a continuous stream of beats with `rd_echo` held high and no idle cycle between bursts.
- R9: A read accepted in the same cycle as a write, or later, returns the merged new data for that address. A read accepted before the write command returns the old data.
- R10: An active-high synchronous reset clears the pipeline, so `rd_echo` is low during reset and after it. Array contents are not changed by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read command |
| rd_addr | input | ADDR_W | Read word address |
| wr_req | input | 1 | Write command |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write beat data |
| wr_nmask | input | DATA_W/4 | Active-low nibble enables for the current beat |
| rd_data | output | DATA_W | Read beat data |
| rd_echo | output | 1 | High in each cycle that carries a read beat |

## Verification
The hardest case is a read and a write to the same address accepted in the same cycle, with partial nibble enables. Here the array fetch and the commit fall on the same clock edge, so the read must merge the pending beats into the stored word. The stimulus first fills every word with known data. It then issues directed same-cycle collisions with enables that differ between the two beats. Finally it runs a long random mix over only eight addresses, which makes collisions in the same cycle and one cycle apart frequent.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;
  localparam int LANE_W = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } beat_phase_e;

  function automatic int lanes_in(input int bits);
    return bits / LANE_W;
  endfunction
endpackage

// File: rtl/sio_wr_demux.sv
module sio_wr_demux
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int NLANE = lanes_in(DATA_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_req,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NLANE-1:0]      wr_nmask,
  output logic                  commit_en,
  output logic [ADDR_W-1:0]     commit_addr,
  output logic [2*DATA_W-1:0]   commit_word,
  output logic [2*NLANE-1:0]    commit_we
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] beat0_q;
  logic [NLANE-1:0]  nmask0_q;
  logic              wr_accept;

  // active-low per-beat enables to active-high word lanes, low beat in low lanes
  function automatic logic [2*NLANE-1:0] lane_enables(input logic [NLANE-1:0] n_hi,
                                                      input logic [NLANE-1:0] n_lo);
    return ~{n_hi, n_lo};
  endfunction

  assign wr_accept = wr_req && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= wr_accept;
  end

  always_ff @(posedge clk) begin
    if (wr_accept) begin
      addr_q   <= wr_addr;
      beat0_q  <= wr_data;
      nmask0_q <= wr_nmask;
    end
  end

  assign commit_en   = busy_q;
  assign commit_addr = addr_q;
  assign commit_word = {wr_data, beat0_q};
  assign commit_we   = lane_enables(wr_nmask, nmask0_q);

  // R4: an accepted command is committed on the following beat
  assert_commit_follows_R4: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> commit_en);

  // R7: two commits can never be adjacent
  assert_commit_gap_R7: assert property (@(posedge clk) disable iff (rst)
    commit_en |=> !commit_en);
endmodule

// File: rtl/sio_array.sv
module sio_array
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  localparam int NL    = lanes_in(WORD_W),
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [NL-1:0]     wr_lanes,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              fwd_hit;
  logic [WORD_W-1:0] hit_bits;

  function automatic logic [WORD_W-1:0] lane_bits(input logic [NL-1:0] lanes);
    logic [WORD_W-1:0] b;
    for (int i = 0; i < NL; i++) b[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
    return b;
  endfunction

  function automatic logic [WORD_W-1:0] merge(input logic [WORD_W-1:0] old_w,
                                              input logic [WORD_W-1:0] new_w,
                                              input logic [NL-1:0]     lanes);
    return (old_w & ~lane_bits(lanes)) | (new_w & lane_bits(lanes));
  endfunction

  assign hit_bits = lane_bits(wr_lanes);
  assign fwd_hit  = wr_en && rd_en && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= merge(mem[wr_addr], wr_word, wr_lanes);
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= fwd_hit ? merge(mem[rd_addr], wr_word, wr_lanes) : mem[rd_addr];
  end

  // R9: a fetch colliding with a commit carries the enabled new nibbles
  assert_fwd_new_R9: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |=> ((rd_word & $past(hit_bits)) == ($past(wr_word) & $past(hit_bits))));
endmodule

// File: rtl/sio_rd_mux.sv
module sio_rd_mux
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_req,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic                fetch_en,
  output logic [ADDR_W-1:0]   fetch_addr,
  input  logic [2*DATA_W-1:0] fetch_word,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_echo
);
  logic              busy_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  beat_phase_e       phase_q;
  logic              rd_accept;

  function automatic beat_phase_e next_phase(input logic fetched, input beat_phase_e cur);
    if (fetched)          return PH_LO;
    else if (cur == PH_LO) return PH_HI;
    else                  return PH_IDLE;
  endfunction

  assign rd_accept = rd_req && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pend_q  <= 1'b0;
      phase_q <= PH_IDLE;
    end else begin
      busy_q  <= rd_accept;
      pend_q  <= rd_accept;
      phase_q <= next_phase(pend_q, phase_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_accept) addr_q <= rd_addr;
  end

  assign fetch_en   = pend_q;
  assign fetch_addr = addr_q;
  assign rd_echo    = (phase_q != PH_IDLE);

  always_comb begin
    unique case (phase_q)
      PH_LO:   rd_data = fetch_word[DATA_W-1:0];
      PH_HI:   rd_data = fetch_word[2*DATA_W-1:DATA_W];
      default: rd_data = '0;
    endcase
  end

  // R2: first beat two cycles after acceptance
  assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
    rd_accept |=> ##1 (phase_q == PH_LO));

  // R8: a low beat is always followed by its high beat
  assert_beat_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LO) |=> (phase_q == PH_HI));
endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int NLANE = lanes_in(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NLANE-1:0]  wr_nmask,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_echo
);
  localparam int WORD_W = 2 * DATA_W;

  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_word;
  logic [2*NLANE-1:0] commit_we;
  logic              fetch_en;
  logic [ADDR_W-1:0] fetch_addr;
  logic [WORD_W-1:0] fetch_word;

  sio_wr_demux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nmask(wr_nmask),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_word(commit_word), .commit_we(commit_we)
  );

  sio_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .rst(rst),
    .wr_en(commit_en), .wr_addr(commit_addr), .wr_word(commit_word), .wr_lanes(commit_we),
    .rd_en(fetch_en), .rd_addr(fetch_addr), .rd_word(fetch_word)
  );

  sio_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .rd_data(rd_data), .rd_echo(rd_echo)
  );
endmodule

// File: tb/tb_sio_b2_sram.sv
`timescale 1ns/1ps
module tb_sio_b2_sram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_req = 1'b0;
  logic [5:0] rd_addr = '0;
  logic       wr_req = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] wr_nmask = 2'b11;
  logic [7:0] rd_data;
  logic       rd_echo;

  sio_b2_sram dut (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_nmask(wr_nmask),
    .rd_data(rd_data), .rd_echo(rd_echo)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit mon_on = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int         exp_cyc[$];
  logic [7:0] exp_dat[$];
  string      exp_tag[$];

  // bench model
  logic [15:0] mem_m [64];
  bit          wbusy = 0, rbusy = 0, fdue = 0;
  int          wacc_addr, faddr;
  logic [7:0]  wacc_d;
  logic [1:0]  wacc_m;
  string       ftag;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // nibble n of the word: beat n/2, lane n%2; a lane is written when its mask bit is 0
  function automatic logic [15:0] apply(input logic [15:0] old_w,
                                        input logic [7:0] b0, input logic [1:0] m0,
                                        input logic [7:0] b1, input logic [1:0] m1);
    logic [15:0] w = old_w;
    logic [15:0] nw = {b1, b0};
    logic [3:0]  off = {m1, m0};
    for (int n = 0; n < 4; n++)
      if (off[n] == 1'b0) w[n*4 +: 4] = nw[n*4 +: 4];
    return w;
  endfunction

  task automatic step(input bit rd, input int ra, input bit wr, input int wa,
                      input logic [7:0] d, input logic [1:0] m, input string tag);
    logic [15:0] w;
    @(negedge clk);
    rd_req = rd; rd_addr = ra[5:0];
    wr_req = wr; wr_addr = wa[5:0];
    wr_data = d; wr_nmask = m;
    if (wbusy) begin
      mem_m[wacc_addr] = apply(mem_m[wacc_addr], wacc_d, wacc_m, d, m);
      wbusy = 0;
    end else if (wr) begin
      wacc_addr = wa; wacc_d = d; wacc_m = m; wbusy = 1;
    end
    if (fdue) begin
      w = mem_m[faddr];
      exp_cyc.push_back(cyc + 1); exp_dat.push_back(w[7:0]);  exp_tag.push_back(ftag);
      exp_cyc.push_back(cyc + 2); exp_dat.push_back(w[15:8]); exp_tag.push_back(ftag);
    end
    fdue = 0;
    if (rbusy) rbusy = 0;
    else if (rd) begin
      rbusy = 1; fdue = 1; faddr = ra; ftag = tag;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 8'h00, 2'b11, "R3");
  endtask

  task automatic write_word(input int a, input logic [15:0] w, input logic [3:0] nm, input string tag);
    step(0, 0, 1, a, w[7:0], nm[1:0], tag);
    step(0, 0, 0, 0, w[15:8], nm[3:2], tag);
  endtask

  task automatic read_word(input int a, input string tag);
    step(1, a, 0, 0, 8'h00, 2'b11, tag);
    step(0, 0, 0, 0, 8'h00, 2'b11, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (rd_echo) begin
        if (exp_cyc.size() == 0) begin
          chk(0, "R7 unexpected beat", int'(rd_data), 0);
        end else begin
          int ec; logic [7:0] ed; string et;
          ec = exp_cyc.pop_front(); ed = exp_dat.pop_front(); et = exp_tag.pop_front();
          chk(ec == cyc, {et, " beat timing"}, cyc, ec);
          chk(rd_data === ed, {et, " beat data"}, int'(rd_data), int'(ed));
        end
      end else begin
        chk(rd_data === 8'h00, "R3 idle data", int'(rd_data), 0);
        if (exp_cyc.size() != 0 && exp_cyc[0] <= cyc)
          chk(0, {exp_tag[0], " missing beat"}, 0, int'(exp_dat[0]));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rd_echo === 1'b0, "R10 echo in reset", int'(rd_echo), 0);
    chk(rd_data === 8'h00, "R10 data in reset", int'(rd_data), 0);
    rst = 1'b0;
    mon_on = 1;

    // R4: fill every word with full enables
    for (int a = 0; a < 64; a++)
      write_word(a, {8'(a ^ 8'hA5), 8'(a * 3 + 1)}, 4'b0000, "R4");
    idle(2);

    // R2 / R8: gapless read stream
    for (int a = 0; a < 16; a++) read_word(a, "R8");
    idle(4);
    read_word(40, "R2");
    idle(4);

    // R7: commands in the second-beat slot are ignored
    step(1, 1, 0, 0, 8'h00, 2'b11, "R7");
    step(1, 2, 0, 0, 8'h00, 2'b11, "R7");
    idle(4);
    step(0, 0, 1, 3, 8'h3C, 2'b00, "R7");
    step(0, 0, 1, 4, 8'hC3, 2'b00, "R7");
    idle(1);
    read_word(3, "R7");
    read_word(4, "R7");
    idle(4);

    // R5 / R6: per-beat nibble enables
    write_word(5, 16'hBEEF, 4'b0110, "R5");
    read_word(5, "R5");
    write_word(20, 16'h1234, 4'b1001, "R6");
    read_word(20, "R6");
    write_word(21, 16'hFFFF, 4'b1111, "R5");
    read_word(21, "R5");
    idle(4);

    // R1: simultaneous read and write, different addresses
    step(1, 6, 1, 7, 8'h71, 2'b00, "R1");
    step(0, 0, 0, 0, 8'h17, 2'b00, "R1");
    read_word(7, "R1");
    idle(4);

    // R9: same-cycle collision with partial enables
    step(1, 8, 1, 8, 8'hD2, 2'b01, "R9");
    step(0, 0, 0, 0, 8'h6E, 2'b10, "R9");
    idle(4);
    // write one cycle before the read
    step(0, 0, 1, 9, 8'h99, 2'b00, "R9");
    step(1, 9, 0, 0, 8'hAA, 2'b00, "R9");
    idle(4);
    // read one cycle before the write: old data
    step(1, 10, 0, 0, 8'h00, 2'b11, "R9");
    step(0, 0, 1, 10, 8'h5A, 2'b00, "R9");
    step(0, 0, 0, 0, 8'hA5, 2'b00, "R9");
    read_word(10, "R9");
    idle(4);

    // random mix over a few addresses
    for (int i = 0; i < 600; i++)
      step(1'($urandom % 2), int'($urandom % 8), 1'($urandom % 2), int'($urandom % 8),
           8'($urandom), 2'($urandom), "R9");
    idle(6);

    // R10: reset keeps the array contents
    @(negedge clk); rst = 1'b1; mon_on = 0;
    rd_req = 0; wr_req = 0;
    @(negedge clk);
    chk(rd_echo === 1'b0, "R10 echo in reset", int'(rd_echo), 0);
    @(negedge clk);
    chk(rd_echo === 1'b0, "R10 echo in reset", int'(rd_echo), 0);
    rst = 1'b0; mon_on = 1;
    for (int a = 0; a < 12; a++) read_word(a, "R10");
    idle(6);

    chk(exp_cyc.size() == 0, "R2 drained", exp_cyc.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule